// File: doc/BRIEF.md
# Rewindable Single-Clock FIFO with Half-Full Status

This block is a first-in/first-out word buffer with a single clock. Each word is 9 bits wide, so a byte can travel with a parity or marker bit beside it. A parameter sets the depth to 256, 512 or 1024 words. The producer and consumer supply no addresses. Two ring pointers inside the block choose the storage location for each access and wrap at the end of the array. Writes and reads are requested with active-low strobes, which the block samples on every rising clock edge.

Three status outputs report the fill level: empty, full, and a half-full flag that rises once more than half of the array is occupied. The full and empty flags also act as guards, so a strobe that would overflow or underflow the buffer is dropped.

A rewind input moves the read side back to the first word written since reset, so a consumer can read the stored stream again, for example to resend a frame after an error. Because read data is registered, a consumer sees a word one clock after its accepted read strobe.

Top module: `fifo_rt_buffer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears both pointers and the occupancy. After that edge, `empty`=1, `full`=0, `half_full`=0 and `dout`=0.
- R2: Words are read back in exactly the order in which they were accepted, with all 9 bits intact.
- R3: A read is accepted when `rd_n`=0, `empty`=0 and `rewind_n`=1 at a rising edge. On that edge `dout` takes the oldest unread word. On any edge without an accepted read, `dout` holds its value.
- R4: `full` is 1 when the buffer holds DEPTH words. A write strobe seen while `full`=1 is dropped and leaves the stored words unchanged.
- R5: `empty` is 1 when the buffer holds no words. A read strobe seen while `empty`=1 is dropped, and neither `dout` nor the read position moves.
- R6: `half_full` is 1 exactly when the occupancy exceeds DEPTH/2. With DEPTH=256, it is 0 at 128 words and 1 at 129 words.
- R7: When a write and a read are both accepted on the same edge, the occupancy does not change.
- R8: `rewind_n`=0 at a rising edge moves the read position to the first word written since reset and sets the occupancy to the number of words written since reset. Both strobes are ignored on that edge. A rewind is valid only while fewer than DEPTH words have been written since reset.
- R9: Both ring pointers wrap from the last location to location 0, and ordering is kept across the wrap.
- R10: DEPTH is a parameter taking 256, 512 or 1024. `full` rises after exactly DEPTH net accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rewind_n | input | 1 | Rewind request, active low |
| din | input | 9 | Word to store |
| dout | output | 9 | Registered read word |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| half_full | output | 1 | More than DEPTH/2 words stored |

## Verification
Every result here is due one clock after the edge that samples the stimulus. The occupancy register drives all three flags, so they change right after that edge. `dout` also changes at that edge, when a read is accepted. Rewinds and dropped strobes show their effect on the following edge. The bench therefore drives inputs on the falling edge and steps its queue model at the rising edge. It then compares every output at the next falling edge, half a period after the registers have settled.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

  localparam int unsigned WORD_W = 9;

  // Depth values the block is specified for.
  function automatic bit f_depth_ok(input int unsigned depth);
    return (depth == 256) || (depth == 512) || (depth == 1024);
  endfunction

  // Occupancy above which the half-full flag is raised.
  function automatic int unsigned f_half_mark(input int unsigned depth);
    return depth / 2;
  endfunction

endpackage

// File: rtl/fifo_rt_ptr.sv
module fifo_rt_ptr #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  // Ring pointer: the natural wrap of AW bits closes the ring.
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (clr)    ptr <= '0;
    else if (adv)    ptr <= ptr + AW'(1);
  end

endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = 9,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // Registered read port: holds the last word when no read is accepted.
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/fifo_rt_occ.sv
module fifo_rt_occ
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          half_full
);

  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(f_half_mark(DEPTH));

  function automatic logic [CW-1:0] f_next(
    input logic [CW-1:0] cur,
    input logic          up,
    input logic          down
  );
    return cur + CW'(up) - CW'(down);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= {1'b0, load_val};
    else           count <= f_next(count, inc, dec);
  end

  assign empty     = (count == '0);
  assign full      = (count == FULL_LVL);
  assign half_full = (count > HALF_LVL);

endmodule

// File: rtl/fifo_rt_buffer.sv
module fifo_rt_buffer
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rewind_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              empty,
  output logic              full,
  output logic              half_full
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  // Named internal events, visible to the bound checker.
  logic          rewind_evt;
  logic          wr_acc;
  logic          rd_acc;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;

  assign rewind_evt = !rewind_n;
  assign wr_acc     = !wr_n && !full  && !rewind_evt;
  assign rd_acc     = !rd_n && !empty && !rewind_evt;

  fifo_rt_ptr #(.AW(AW)) u_wr_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (1'b0),
    .adv   (wr_acc),
    .ptr   (wr_ptr)
  );

  fifo_rt_ptr #(.AW(AW)) u_rd_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rewind_evt),
    .adv   (rd_acc),
    .ptr   (rd_ptr)
  );

  fifo_rt_mem #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_acc),
    .waddr (wr_ptr),
    .wdata (din),
    .re    (rd_acc),
    .raddr (rd_ptr),
    .rdata (dout)
  );

  fifo_rt_occ #(.DEPTH(DEPTH)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (wr_acc),
    .dec       (rd_acc),
    .load      (rewind_evt),
    .load_val  (wr_ptr),
    .count     (count),
    .empty     (empty),
    .full      (full),
    .half_full (half_full)
  );

endmodule

// File: rtl/fifo_rt_buffer_chk.sv
module fifo_rt_buffer_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic          rd_n,
  input logic          rewind_n,
  input logic [8:0]    dout,
  input logic          empty,
  input logic          full,
  input logic          half_full,
  input logic          wr_acc,
  input logic          rd_acc,
  input logic [AW-1:0] wr_ptr,
  input logic [CW-1:0] count
);

  // R4: a write strobe while full, with no read, leaves the occupancy alone
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_n && rd_n && rewind_n) |=> (full && $stable(count)));

  // R5: a read strobe while empty, with no write, moves nothing
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rd_n && wr_n && rewind_n) |=> (empty && $stable(dout)));

  // R3: the output word holds unless a read was accepted
  a_r3_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(dout));

  // R7: a write and a read together keep the occupancy
  a_r7_paired_access: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && rd_acc) |=> $stable(count));

  // R8: a rewind loads the occupancy from the write position and drops the write
  a_r8_rewind_load: assert property (@(posedge clk) disable iff (!rst_n)
    !rewind_n |=> ((count == CW'($past(wr_ptr))) && $stable(wr_ptr)));

  // R4, R5: the extreme flags never coincide
  a_r4_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  // R6: half-full implies data present
  a_r6_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    half_full |-> !empty);

endmodule

bind fifo_rt_buffer fifo_rt_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_n      (wr_n),
  .rd_n      (rd_n),
  .rewind_n  (rewind_n),
  .dout      (dout),
  .empty     (empty),
  .full      (full),
  .half_full (half_full),
  .wr_acc    (wr_acc),
  .rd_acc    (rd_acc),
  .wr_ptr    (wr_ptr),
  .count     (count)
);

// File: tb/fifo_rt_buffer_tb.sv
module fifo_rt_buffer_tb_top;

  localparam int D = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       rewind_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic       empty, full, half_full;

  always #2 clk = ~clk;  // 250 MHz

  fifo_rt_buffer #(.DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rewind_n(rewind_n),
    .din(din), .dout(dout), .empty(empty), .full(full), .half_full(half_full)
  );

  // Behavioural model: everything written since reset plus a read index.
  logic [8:0] hist[$];
  int         rd_i = 0;
  logic [8:0] m_dout = '0;
  int         n_vec = 0;
  int         n_bad = 0;

  function automatic int occ();
    return hist.size() - rd_i;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(dout == m_dout, "R2 dout", int'(dout), int'(m_dout));
    chk(empty == (occ() == 0), "R5 empty", int'(empty), int'(occ() == 0));
    chk(full == (occ() == D), "R4 full", int'(full), int'(occ() == D));
    chk(half_full == (occ() > D/2), "R6 half_full", int'(half_full), int'(occ() > D/2));
  endtask

  // One clock: drive at the falling edge, step the model, compare at the next falling edge.
  task automatic cyc(input bit rst, input bit w, input bit r, input bit rt, input logic [8:0] d);
    int o;
    rst_n = !rst; wr_n = !w; rd_n = !r; rewind_n = !rt; din = d;
    o = occ();
    if (rst) begin
      hist.delete(); rd_i = 0; m_dout = '0;
    end else if (rt) begin
      rd_i = 0;
    end else begin
      if (r && o > 0) begin m_dout = hist[rd_i]; rd_i++; end
      if (w && o < D) hist.push_back(d);
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL all: watchdog expired, actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [8:0] held;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, '0);
    chk(empty && !full && !half_full && dout == 0, "R1 reset flags", int'({empty, full, half_full}), 4);

    // R2, R3 ordering and read latency
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, pat(i));
    cyc(0, 0, 1, 0, '0);
    chk(dout == pat(0), "R3 word after one read", int'(dout), int'(pat(0)));
    cyc(0, 0, 0, 0, '0);
    chk(dout == pat(0), "R3 hold when idle", int'(dout), int'(pat(0)));
    for (int i = 0; i < 11; i++) cyc(0, i % 2 == 0, 1, 0, pat(100 + i));
    while (occ() > 0) cyc(0, 0, 1, 0, '0);

    // R5 reads on empty are dropped
    held = dout;
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, '0);
    chk(empty && dout == held, "R5 read on empty", int'(dout), int'(held));

    // R6, R4, R10 fill past full
    cyc(1, 0, 0, 0, '0);
    for (int i = 0; i < 128; i++) cyc(0, 1, 0, 0, pat(i));
    chk(!half_full, "R6 at half mark", int'(half_full), 0);
    cyc(0, 1, 0, 0, pat(128));
    chk(half_full, "R6 above half mark", int'(half_full), 1);
    for (int i = 129; i < D - 1; i++) cyc(0, 1, 0, 0, pat(i));
    chk(!full, "R10 one short of depth", int'(full), 0);
    cyc(0, 1, 0, 0, pat(D - 1));
    chk(full, "R10 full at depth", int'(full), 1);
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 0, 9'h1FF);
    cyc(0, 0, 1, 0, '0);
    chk(dout == pat(0), "R4 oldest word not overwritten", int'(dout), int'(pat(0)));
    cyc(0, 1, 1, 0, 9'h0AA);
    while (occ() > 0) cyc(0, 0, 1, 0, '0);
    chk(dout == 9'h0AA, "R4 last word after refill", int'(dout), 9'h0AA);

    // R7 paired accesses keep the occupancy
    cyc(1, 0, 0, 0, '0);
    for (int i = 0; i < 100; i++) cyc(0, 1, 0, 0, pat(i));
    for (int i = 0; i < 50; i++) cyc(0, 1, 1, 0, pat(300 + i));
    for (int i = 0; i < 28; i++) cyc(0, 1, 0, 0, pat(400 + i));
    chk(!half_full, "R7 occupancy 128 after pairs", int'(half_full), 0);
    cyc(0, 1, 0, 0, pat(500));
    chk(half_full, "R7 occupancy 129 after pairs", int'(half_full), 1);

    // R8 rewind replays from the first word
    cyc(1, 0, 0, 0, '0);
    for (int i = 0; i < 20; i++) cyc(0, 1, 0, 0, pat(i + 7));
    for (int i = 0; i < 7; i++) cyc(0, 0, 1, 0, '0);
    held = dout;
    cyc(0, 1, 1, 1, 9'h155);
    chk(dout == held, "R8 strobes dropped on rewind", int'(dout), int'(held));
    for (int i = 0; i < 20; i++) begin
      cyc(0, 0, 1, 0, '0);
      chk(dout == pat(i + 7), "R8 replay word", int'(dout), int'(pat(i + 7)));
    end
    chk(empty, "R8 empty after replay", int'(empty), 1);

    // R9 wrap of both pointers
    cyc(1, 0, 0, 0, '0);
    base = n_bad;
    for (int i = 0; i < 900; i++) cyc(0, (i % 3) != 2, (i % 3) != 0 && i > 20, 0, pat(i));
    while (occ() > 0) cyc(0, 0, 1, 0, '0);
    chk(n_bad == base && hist.size() > 2 * D, "R9 ordering across wrap", n_bad - base, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule